// File: doc/BRIEF.md
# Exception History Buffer

This block keeps, for every register-writing instruction still in flight, the value its destination register held before that instruction overwrote it. A register file that is written out of order can then be put back into a precise state when an instruction faults. Decode claims an entry in program order and receives a tag, which is the index of that entry. When the instruction later finishes and writes its result, the completing unit hands over the value it is about to overwrite, and that old value is stored under the tag. Entries are released strictly oldest-first as soon as the oldest one has completed. In normal operation nothing is ever read back out.

When an exception is reported against an in-flight tag, the buffer walks its entries from the youngest back to the faulting one, one entry per cycle. Each entry whose instruction had completed drives its saved value onto a register write port. Entries that never completed are stepped over without a write. A busy output stays high for the whole walk. Decode is stalled while the buffer is full, while the walk runs, and in the cycle an exception is presented. The depth must be a power of two.

Top module: `exc_history_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `busy` is 0 and `rf_we` is 0.
- R2: An allocation is accepted in a cycle with `alloc_valid` and `alloc_ready` both high. The tag it receives is `alloc_tag`, which starts at 0 and advances by one per accepted allocation, wrapping from DEPTH-1 to 0.
- R3: With DEPTH entries in flight, `alloc_ready` is 0 and further allocations are not accepted.
- R4: A completion (`cmpl_valid`) on an in-flight tag, outside a walk, marks that entry complete and stores `cmpl_data` as its old register value.
- R5: Only the oldest entry can be released, one per cycle, at the clock edge after it has become complete. A completed younger entry stays occupied while an older one is incomplete.
- R6: `rf_we` is never high while `busy` is low.
- R7: An exception (`exc_valid`, `exc_tag` in flight, `busy` low) raises `busy` from the next cycle for exactly N cycles, where N is the number of entries from `exc_tag` up to the youngest. In the k-th busy cycle (k from 0), the entry that is k places older than the youngest is presented, and if it is complete, `rf_we`=1 with its register ID on `rf_waddr` and its old value on `rf_wdata`.
- R8: During the walk, an entry that was not complete drives `rf_we`=0 in its cycle.
- R9: `alloc_ready` is 0 while `busy` is high and in any cycle with `exc_valid` high. After the walk, the next tag handed out equals the faulting tag, because the faulting entry and all younger entries are discarded.
- R10: An exception on a tag that is not in flight, or one raised while `busy` is high, is ignored and starts no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode requests an entry |
| alloc_reg | input | RW (5) | Destination register ID of the decoding instruction |
| alloc_ready | output | 1 | An entry can be claimed this cycle |
| alloc_tag | output | log2(DEPTH) (3) | Tag given to the allocation |
| cmpl_valid | input | 1 | An instruction completes |
| cmpl_tag | input | log2(DEPTH) (3) | Tag of the completing instruction |
| cmpl_data | input | DW (32) | Value its destination held before the write |
| exc_valid | input | 1 | An exception is reported |
| exc_tag | input | log2(DEPTH) (3) | Tag of the faulting instruction |
| busy | output | 1 | Restore walk in progress |
| rf_we | output | 1 | Register restore write enable |
| rf_waddr | output | RW (5) | Register to restore |
| rf_wdata | output | DW (32) | Value to restore |

## Verification
`alloc_ready` and `alloc_tag` respond in the same cycle, so the bench checks them just after it changes its inputs and before the clock edge. Completion and release act at the next edge, which means a freed entry shows on `alloc_ready` two edges after its completion is presented. The first restore is due in the cycle after the edge that accepts the exception, and each later entry follows one cycle after the one before. The driver therefore pushes the expected walk, with skips included, into a queue at the exception edge. A monitor takes one item from that queue at every falling edge while `busy` is high, and the queue must be empty when `busy` drops.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HB_DEPTH_DEF = 8;
  localparam int HB_REG_W_DEF = 5;
  localparam int HB_DATA_W_DEF = 32;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_t;
endpackage

// File: rtl/hb_entry_store.sv
module hb_entry_store #(
  parameter int DEPTH = 8,
  parameter int RW = 5,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic [IW-1:0] alloc_idx,
  input  logic [RW-1:0] alloc_reg,
  input  logic          cmpl_fire,
  input  logic [IW-1:0] cmpl_idx,
  input  logic [DW-1:0] cmpl_data,
  input  logic [IW-1:0] head_idx,
  input  logic [IW-1:0] walk_idx,
  output logic          head_done,
  output logic          walk_done,
  output logic [RW-1:0] walk_reg,
  output logic [DW-1:0] walk_data
);
  logic [DEPTH-1:0]         done_vec;
  logic [DEPTH-1:0][RW-1:0] reg_vec;
  logic [DEPTH-1:0][DW-1:0] data_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : gen_ent
    logic          done_r;
    logic [RW-1:0] reg_r;
    logic [DW-1:0] data_r;
    logic          hit_alloc;
    logic          hit_cmpl;

    assign hit_alloc = alloc_fire && (alloc_idx == IW'(i));
    assign hit_cmpl  = cmpl_fire && (cmpl_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        done_r <= 1'b0;
        reg_r  <= '0;
        data_r <= '0;
      end else if (hit_alloc) begin
        done_r <= 1'b0;
        reg_r  <= alloc_reg;
      end else if (hit_cmpl) begin
        done_r <= 1'b1;
        data_r <= cmpl_data;
      end
    end

    assign done_vec[i] = done_r;
    assign reg_vec[i]  = reg_r;
    assign data_vec[i] = data_r;
  end

  assign head_done = done_vec[head_idx];
  assign walk_done = done_vec[walk_idx];
  assign walk_reg  = reg_vec[walk_idx];
  assign walk_data = data_vec[walk_idx];

  // R4: a captured completion leaves its entry complete with the handed-over value
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_fire |=> done_vec[$past(cmpl_idx)] && data_vec[$past(cmpl_idx)] == $past(cmpl_data));

  // R2: a fresh allocation starts out incomplete
  assert_fresh_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !done_vec[$past(alloc_idx)]);
endmodule

// File: rtl/hb_ring_ctrl.sv
module hb_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          cmpl_valid,
  input  logic [IW-1:0] cmpl_tag,
  input  logic          exc_valid,
  input  logic [IW-1:0] exc_tag,
  input  logic          busy,
  input  logic          head_done,
  output logic [IW-1:0] head_idx,
  output logic          alloc_fire,
  output logic          cmpl_fire,
  output logic          exc_fire,
  output logic [IW-1:0] walk_start,
  output logic [CW-1:0] walk_len
);
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;
  logic          retire_fire;
  logic          is_full, is_empty;

  // distance of a tag from the oldest entry, modulo the ring size
  function automatic logic [CW-1:0] age_of(input logic [IW-1:0] tag, input logic [IW-1:0] hd);
    logic [IW-1:0] diff;
    diff = tag - hd;
    return {1'b0, diff};
  endfunction

  function automatic logic live_tag(input logic [IW-1:0] tag, input logic [IW-1:0] hd,
                                    input logic [CW-1:0] cnt);
    return age_of(tag, hd) < cnt;
  endfunction

  assign is_full     = (count_q == CW'(DEPTH));
  assign is_empty    = (count_q == '0);
  assign alloc_ready = !is_full && !busy && !exc_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign cmpl_fire   = cmpl_valid && !busy && live_tag(cmpl_tag, head_q, count_q);
  assign exc_fire    = exc_valid && !busy && live_tag(exc_tag, head_q, count_q);
  assign retire_fire = !busy && !exc_valid && !is_empty && head_done;
  assign alloc_tag   = tail_q;
  assign head_idx    = head_q;
  assign walk_start  = tail_q - IW'(1);
  assign walk_len    = count_q - age_of(exc_tag, head_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (exc_fire) begin
      tail_q  <= exc_tag;
      count_q <= age_of(exc_tag, head_q);
    end else begin
      if (alloc_fire)  tail_q <= tail_q + IW'(1);
      if (retire_fire) head_q <= head_q + IW'(1);
      count_q <= count_q + CW'(alloc_fire) - CW'(retire_fire);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  assert_full_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_full |-> !alloc_fire);

  assert_walk_blocks_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !alloc_ready);

  // R5: an incomplete oldest entry keeps the occupancy from shrinking
  assert_in_order_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!head_done && !exc_fire) |=> count_q >= $past(count_q));

  // R9: after an exception the next tag is the faulting one
  assert_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> tail_q == $past(exc_tag));
endmodule

// File: rtl/hb_unwind.sv
module hb_unwind #(
  parameter int DEPTH = 8,
  parameter int RW = 5,
  parameter int DW = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_fire,
  input  logic [IW-1:0] walk_start,
  input  logic [CW-1:0] walk_len,
  input  logic          walk_done,
  input  logic [RW-1:0] walk_reg,
  input  logic [DW-1:0] walk_data,
  output logic          busy,
  output logic [IW-1:0] walk_idx,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  import hb_pkg::*;

  walk_state_t   state_q;
  logic [IW-1:0] ptr_q;
  logic [CW-1:0] left_q;
  logic          last_step;

  assign busy      = (state_q == WALK_RUN);
  assign walk_idx  = ptr_q;
  assign last_step = busy && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
    end else if (!busy) begin
      if (exc_fire) begin
        state_q <= WALK_RUN;
        ptr_q   <= walk_start;
        left_q  <= walk_len - CW'(1);
      end
    end else if (last_step) begin
      state_q <= WALK_IDLE;
    end else begin
      ptr_q  <= ptr_q - IW'(1);
      left_q <= left_q - CW'(1);
    end
  end

  assign rf_we    = busy && walk_done;
  assign rf_waddr = rf_we ? walk_reg : '0;
  assign rf_wdata = rf_we ? walk_data : '0;

  assert_quiet_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy);

  assert_walk_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_fire |=> busy && walk_idx == $past(walk_start));

  assert_walk_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy && walk_idx == $past(walk_idx) - IW'(1));

  assert_walk_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy);
endmodule

// File: rtl/exc_history_buf.sv
module exc_history_buf #(
  parameter int DEPTH = hb_pkg::HB_DEPTH_DEF,
  parameter int RW = hb_pkg::HB_REG_W_DEF,
  parameter int DW = hb_pkg::HB_DATA_W_DEF,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [RW-1:0] alloc_reg,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_tag,
  input  logic          cmpl_valid,
  input  logic [IW-1:0] cmpl_tag,
  input  logic [DW-1:0] cmpl_data,
  input  logic          exc_valid,
  input  logic [IW-1:0] exc_tag,
  output logic          busy,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata
);
  logic          alloc_fire, cmpl_fire, exc_fire;
  logic          head_done, walk_done;
  logic [IW-1:0] head_idx, walk_idx, walk_start;
  logic [CW-1:0] walk_len;
  logic [RW-1:0] walk_reg;
  logic [DW-1:0] walk_data;

  hb_ring_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
    .exc_valid(exc_valid), .exc_tag(exc_tag),
    .busy(busy), .head_done(head_done), .head_idx(head_idx),
    .alloc_fire(alloc_fire), .cmpl_fire(cmpl_fire), .exc_fire(exc_fire),
    .walk_start(walk_start), .walk_len(walk_len)
  );

  hb_entry_store #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) i_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_fire(alloc_fire), .alloc_idx(alloc_tag), .alloc_reg(alloc_reg),
    .cmpl_fire(cmpl_fire), .cmpl_idx(cmpl_tag), .cmpl_data(cmpl_data),
    .head_idx(head_idx), .walk_idx(walk_idx),
    .head_done(head_done), .walk_done(walk_done),
    .walk_reg(walk_reg), .walk_data(walk_data)
  );

  hb_unwind #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) i_unwind (
    .clk(clk), .rst_n(rst_n),
    .exc_fire(exc_fire), .walk_start(walk_start), .walk_len(walk_len),
    .walk_done(walk_done), .walk_reg(walk_reg), .walk_data(walk_data),
    .busy(busy), .walk_idx(walk_idx),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  // R10: an exception while the walk runs does not restart it
  assert_ignore_nested_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exc_valid) |-> !exc_fire);
endmodule

// File: tb/test_exc_history_buf.sv
module test_exc_history_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [RW-1:0] alloc_reg = '0;
  logic          alloc_ready;
  logic [IW-1:0] alloc_tag;
  logic          cmpl_valid = 1'b0;
  logic [IW-1:0] cmpl_tag = '0;
  logic [DW-1:0] cmpl_data = '0;
  logic          exc_valid = 1'b0;
  logic [IW-1:0] exc_tag = '0;
  logic          busy, rf_we;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  exc_history_buf i_exc_history_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_data(cmpl_data),
    .exc_valid(exc_valid), .exc_tag(exc_tag),
    .busy(busy), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int bad = 0;

  typedef struct packed {
    logic          we;
    logic [RW-1:0] r;
    logic [DW-1:0] d;
  } restore_t;
  restore_t exp_q[$];
  restore_t cur;

  // reference state built from the requirements
  logic [RW-1:0] m_reg[DEPTH];
  logic [DW-1:0] m_data[DEPTH];
  logic          m_done[DEPTH];
  int m_head = 0, m_tail = 0, m_count = 0, m_walk = 0;

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int age(input int t);
    return (t - m_head + DEPTH) % DEPTH;
  endfunction

  // scoreboard monitor: one expected walk item per busy cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (exp_q.size() == 0) begin
          check_eq("R7", "walk longer than expected", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          if (cur.we) begin
            check_eq("R7", "restore enable", rf_we, 1);
            check_eq("R7", "restore register", rf_waddr, cur.r);
            check_eq("R7", "restore value", rf_wdata, cur.d);
          end else begin
            check_eq("R8", "skip of incomplete entry", rf_we, 0);
          end
        end
      end else begin
        check_eq("R6", "write port idle outside walk", rf_we, 0);
      end
    end
  end

  task automatic step();
    int  len, idx;
    bit  busy0, exp_ready, cmpl_go, exc_go, alloc_go, ret_go;
    #1;
    busy0 = (m_walk > 0);
    exp_ready = (m_count < DEPTH) && !busy0 && !exc_valid;
    if (m_count == DEPTH)
      check_eq("R3", "alloc_ready when full", alloc_ready, exp_ready);
    else
      check_eq("R9", "alloc_ready", alloc_ready, exp_ready);
    check_eq("R2", "alloc_tag", alloc_tag, m_tail);
    check_eq("R7", "busy", busy, busy0);
    cmpl_go  = cmpl_valid && !busy0 && (age(cmpl_tag) < m_count);
    exc_go   = exc_valid && !busy0 && (age(exc_tag) < m_count);
    alloc_go = alloc_valid && exp_ready;
    ret_go   = !busy0 && !exc_valid && (m_count > 0) && m_done[m_head];
    @(posedge clk);
    if (busy0) m_walk--;
    if (cmpl_go) begin
      m_done[cmpl_tag] = 1'b1;
      m_data[cmpl_tag] = cmpl_data;
    end
    if (exc_go) begin
      len = m_count - age(exc_tag);
      for (int k = 0; k < len; k++) begin
        idx = (m_tail - 1 - k + 2 * DEPTH) % DEPTH;
        exp_q.push_back({m_done[idx], m_reg[idx], m_done[idx] ? m_data[idx] : '0});
      end
      m_count = age(exc_tag);
      m_tail  = exc_tag;
      m_walk  = len;
    end else begin
      if (alloc_go) begin
        m_reg[m_tail]  = alloc_reg;
        m_done[m_tail] = 1'b0;
        m_tail = (m_tail + 1) % DEPTH;
        m_count++;
      end
      if (ret_go) begin
        m_head = (m_head + 1) % DEPTH;
        m_count--;
      end
    end
    @(negedge clk);
  endtask

  task automatic do_alloc(input int r);
    alloc_valid = 1'b1; alloc_reg = RW'(r);
    step();
    alloc_valid = 1'b0;
  endtask

  task automatic do_cmpl(input int t, input logic [DW-1:0] d);
    cmpl_valid = 1'b1; cmpl_tag = IW'(t); cmpl_data = d;
    step();
    cmpl_valid = 1'b0;
  endtask

  task automatic do_exc(input int t);
    exc_valid = 1'b1; exc_tag = IW'(t);
    step();
    exc_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_walk();
    while (m_walk > 0) step();
    check_eq("R7", "restores left after walk", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_reg[i] = '0; m_data[i] = '0; m_done[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check_eq("R1", "alloc_ready after reset", alloc_ready, 1);
    check_eq("R1", "alloc_tag after reset", alloc_tag, 0);
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "rf_we after reset", rf_we, 0);
    @(negedge clk);

    // R2 fill in order, R3 full stall
    for (int i = 0; i < DEPTH; i++) do_alloc(10 + i);
    do_alloc(30);
    do_alloc(31);

    // R5: a younger completion does not free anything
    do_cmpl(3, 32'h3333_0003);
    idle(2);
    do_alloc(30);
    // completing the oldest frees it, then one allocation wraps to tag 0
    do_cmpl(0, 32'hA0A0_0000);
    step();
    do_alloc(20);
    do_alloc(21);

    // R7/R8: mixed completion pattern, fault at tag 4
    do_cmpl(5, 32'h5555_0005);
    do_cmpl(7, 32'h7777_0007);
    do_cmpl(0, 32'h0000_BEEF);
    do_exc(4);
    // R10/R9: nested exception and decode both ignored during the walk
    exc_valid = 1'b1; exc_tag = 3'd2; alloc_valid = 1'b1; alloc_reg = 5'd9;
    step();
    exc_valid = 1'b0; alloc_valid = 1'b0;
    finish_walk();

    // R9: next tag is the faulting one
    do_alloc(22);
    // R10: exception on a tag not in flight
    do_exc(6);
    idle(2);

    // R5: release entries 1..3 in order
    do_cmpl(1, 32'h1111_0001);
    do_cmpl(2, 32'h2222_0002);
    idle(3);
    // fault at the oldest, incomplete: single skip
    do_exc(4);
    finish_walk();

    // fault at the oldest with a same-cycle completion of it
    do_alloc(23);
    do_alloc(24);
    cmpl_valid = 1'b1; cmpl_tag = 3'd4; cmpl_data = 32'hCAFE_0004;
    do_exc(4);
    cmpl_valid = 1'b0;
    finish_walk();
    do_alloc(25);
    idle(2);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule